// File: doc/BRIEF.md
# Hierarchical Statechart Step Engine

This block runs a hierarchical state machine whose shape is fixed at elaboration time through parameter tables. Each transition has a source state, a mask of the events that trigger it, a mask of earlier transitions it conflicts with, a mask of the states it leaves and a mask of the states it targets. Each state has a parent, a kind (leaf, compound, parallel or final) and a default child. On every clock edge where the engine is not stalled it takes one microstep. It picks a conflict-free set of transitions, computes which states are left and which are entered, and writes the new active-state vector.

The engine runs in two modes. In spontaneous mode only eventless transitions can fire. In event mode one event is taken from an internal queue and only transitions that listen for that event can fire. Events arrive over a valid/ready stream. The queue accepts a beat when `ev_valid` and `ev_ready` are both high. `ev_ready` is low while the queue is full. A beat offered while `ev_ready` is low is not accepted, and the sender may hold it or withdraw it. The exit, entry and selected-transition vectors are combinational views of the step being taken in the current cycle. They are zero whenever the engine is stalled.

Top module: `hsm_step_engine`

## Requirements
- R1: While reset is high, `active_o` and `error` are zero and `ev_ready` is high. The first unstalled step after reset enters state 0 (the root) together with its default-child chain. With the default chart this sets `active_o` to 8'h07.
- R2: The engine leaves reset in spontaneous mode. A spontaneous step that selects at least one transition keeps that mode, and so does the first step after reset. A spontaneous step that selects nothing switches the engine to event mode.
- R3: Each unstalled step in event mode pops one event from the queue and uses it. The next step is a spontaneous one, so an eventless transition enabled by that event's result fires on the following edge.
- R4: A transition is a candidate when its source state is active and one of two cases holds. Either its event mask is all-zero and the engine is in spontaneous mode, or the engine is in event mode and mask bit `e` is set for the current event id `e`. A popped event that matches no candidate changes nothing.
- R5: Transitions are considered in ascending index order. A candidate is dropped when it has a conflict-mask bit set for a lower-indexed transition that is already selected. Conflict bits at the transition's own index or above are ignored. `sel_o` bit i corresponds to transition i.
- R6: `exit_o` has bit s set exactly when state s is active and some selected transition has bit s set in its exit mask.
- R7: A state is reached when it is the target of a selected transition or one of its children is reached. Every child of a reached parallel state is reached too. `entry_o` is the set of reached states that are either inactive or being exited.
- R8: A compound state's default child is reached when the compound is reached and no other child of it either stays active after exits or is itself reached.
- R9: After each unstalled edge, `active_o` equals the previous active vector with the `exit_o` bits cleared and the `entry_o` bits set.
- R10: The engine holds all state, and drives zero on `sel_o`, `exit_o` and `entry_o`, in three cases: `en` is low, `completed` is high, or the queue is empty while the engine is in event mode.
- R11: `completed` is high while any final state whose parent is the root is active.
- R12: The event queue holds QDEPTH entries. `ev_ready` is low while it is full, and a beat offered then is not stored.
- R13: `error` goes high on the clock edge after the queue is first seen full. It stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable; low stalls the engine |
| ev_valid | input | 1 | Event beat offered |
| ev_ready | output | 1 | Queue can accept a beat |
| ev_id | input | EW | Event id, 0 to NE-1 |
| active_o | output | NS | Active-state vector, bit s is state s |
| exit_o | output | NS | States left in the current step |
| entry_o | output | NS | States entered in the current step |
| sel_o | output | NT | Transitions selected in the current step |
| completed | output | 1 | A top-level final state is active |
| error | output | 1 | Sticky queue-full indication |

## Verification
The bench uses the default parameters: eight states, five transitions, three events and a queue of depth four. The default chart has a compound state with an eventless inner transition, a parallel region with two leaves, and a top-level final state. It also has two transitions that share one event from sibling sources, joined by a one-way conflict bit, plus an upward conflict bit that must be ignored. A depth of four lets the bench fill the queue with four writes while the engine is held. It can then observe the blocked fifth beat, the sticky error, and the drain through alternating event and spontaneous steps.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
  typedef enum logic [1:0] {
    K_LEAF  = 2'd0,
    K_SEQ   = 2'd1,
    K_PAR   = 2'd2,
    K_FINAL = 2'd3
  } kind_e;
endpackage

// File: rtl/hsm_evq.sv
module hsm_evq #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);
  assign in_ready = ~full;
  assign do_push  = in_valid & ~full;
  assign do_pop   = pop & ~empty;
  assign head     = mem[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) begin
        mem[wp] <= in_data;
        wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (do_pop) begin
        rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/hsm_select.sv
module hsm_select #(
  parameter int              NS    = 8,
  parameter int              NT    = 5,
  parameter int              NE    = 3,
  parameter int              SW    = 3,
  parameter int              EW    = 2,
  parameter logic [NT*SW-1:0] T_SRC  = '0,
  parameter logic [NT*NE-1:0] T_EV   = '0,
  parameter logic [NT*NT-1:0] T_CONF = '0
) (
  input  logic [NS-1:0] active,
  input  logic          go,
  input  logic          spont,
  input  logic [EW-1:0] ev_cur,
  output logic [NT-1:0] sel,
  output logic          any_sel
);
  logic [NT-1:0] cand;

  for (genvar i = 0; i < NT; i++) begin : g_cand
    localparam logic [NE-1:0] EVM = T_EV[i*NE +: NE];
    localparam int            SRC = int'(T_SRC[i*SW +: SW]);
    logic ev_hit;
    assign ev_hit  = (int'(ev_cur) < NE) ? EVM[ev_cur] : 1'b0;
    assign cand[i] = go & active[SRC] &
                     ((EVM == '0) ? spont : (~spont & ev_hit));
  end

  always_comb begin
    logic [NT-1:0] acc;
    acc = '0;
    for (int i = 0; i < NT; i++) begin
      logic [NT-1:0] lower;
      lower = '0;
      for (int j = 0; j < i; j++) lower[j] = 1'b1;
      if (cand[i] && ((T_CONF[i*NT +: NT] & lower & acc) == '0))
        acc[i] = 1'b1;
    end
    sel = acc;
  end

  assign any_sel = |sel;
endmodule

// File: rtl/hsm_config.sv
module hsm_config
  import hsm_pkg::*;
#(
  parameter int              NS       = 8,
  parameter int              NT       = 5,
  parameter int              SW       = 3,
  parameter logic [NT*NS-1:0] T_EXIT   = '0,
  parameter logic [NT*NS-1:0] T_TGT    = '0,
  parameter logic [NS*SW-1:0] S_PARENT = '0,
  parameter logic [NS*2-1:0]  S_KIND   = '0,
  parameter logic [NS*SW-1:0] S_DEF    = '0
) (
  input  logic [NS-1:0] active,
  input  logic [NT-1:0] sel,
  input  logic          boot,
  output logic [NS-1:0] exit_set,
  output logic [NS-1:0] entry_set,
  output logic [NS-1:0] next_active
);
  logic [NS-1:0] reached;

  always_comb begin
    logic [NS-1:0] ex;
    ex = '0;
    for (int i = 0; i < NT; i++)
      if (sel[i]) ex = ex | T_EXIT[i*NS +: NS];
    exit_set = ex & active;
  end

  always_comb begin
    logic [NS-1:0] up, occ, full;
    up = '0;
    for (int i = 0; i < NT; i++)
      if (sel[i]) up = up | T_TGT[i*NS +: NS];
    if (boot) up[0] = 1'b1;
    for (int s = NS - 1; s > 0; s--) begin
      int p;
      p = int'(S_PARENT[s*SW +: SW]);
      if (up[s]) up[p] = 1'b1;
    end
    occ = '0;
    for (int s = 1; s < NS; s++) begin
      int p;
      p = int'(S_PARENT[s*SW +: SW]);
      if ((active[s] && !exit_set[s]) || up[s]) occ[p] = 1'b1;
    end
    full = up;
    for (int s = 1; s < NS; s++) begin
      int    p;
      kind_e pk;
      p  = int'(S_PARENT[s*SW +: SW]);
      pk = kind_e'(S_KIND[p*2 +: 2]);
      if (full[p]) begin
        if (pk == K_PAR) full[s] = 1'b1;
        else if (pk == K_SEQ && int'(S_DEF[p*SW +: SW]) == s && !occ[p])
          full[s] = 1'b1;
      end
    end
    reached = full;
  end

  assign entry_set   = reached & (~active | exit_set);
  assign next_active = (active & ~exit_set) | entry_set;
endmodule

// File: rtl/hsm_step_engine.sv
module hsm_step_engine
  import hsm_pkg::*;
#(
  parameter int NS     = 8,
  parameter int NT     = 5,
  parameter int NE     = 3,
  parameter int QDEPTH = 4,
  parameter int SW     = (NS > 1) ? $clog2(NS) : 1,
  parameter int EW     = (NE > 1) ? $clog2(NE) : 1,
  parameter logic [NT*SW-1:0] T_SRC  = {3'd3, 3'd6, 3'd5, 3'd3, 3'd2},
  parameter logic [NT*NE-1:0] T_EV   = {3'b100, 3'b010, 3'b010, 3'b001, 3'b000},
  parameter logic [NT*NT-1:0] T_CONF = {5'b00000, 5'b00100, 5'b01000, 5'b00000, 5'b00000},
  parameter logic [NT*NS-1:0] T_EXIT = {8'h08, 8'h70, 8'h70, 8'h0E, 8'h04},
  parameter logic [NT*NS-1:0] T_TGT  = {8'h04, 8'h02, 8'h80, 8'h10, 8'h08},
  parameter logic [NS*SW-1:0] S_PARENT = {3'd0, 3'd4, 3'd4, 3'd0, 3'd1, 3'd1, 3'd0, 3'd0},
  parameter logic [NS*2-1:0]  S_KIND   = {2'd3, 2'd0, 2'd0, 2'd2, 2'd0, 2'd0, 2'd1, 2'd1},
  parameter logic [NS*SW-1:0] S_DEF    = {3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd2, 3'd1}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          ev_valid,
  output logic          ev_ready,
  input  logic [EW-1:0] ev_id,
  output logic [NS-1:0] active_o,
  output logic [NS-1:0] exit_o,
  output logic [NS-1:0] entry_o,
  output logic [NT-1:0] sel_o,
  output logic          completed,
  output logic          error
);
  function automatic logic [NS-1:0] top_final_mask();
    logic [NS-1:0] m;
    m = '0;
    for (int s = 1; s < NS; s++)
      if (kind_e'(S_KIND[s*2 +: 2]) == K_FINAL && S_PARENT[s*SW +: SW] == '0)
        m[s] = 1'b1;
    return m;
  endfunction

  localparam logic [NS-1:0] TOP_FINAL = top_final_mask();

  logic [NS-1:0] active, next_active, exit_raw, entry_raw;
  logic [NT-1:0] sel;
  logic          spont, boot, err_q;
  logic          q_empty, q_full, stall, go, pop, any_sel;
  logic [EW-1:0] ev_cur;

  assign completed = |(active & TOP_FINAL);
  assign stall     = ~en | completed | (q_empty & ~spont);
  assign go        = ~stall;
  assign pop       = go & ~spont;

  hsm_evq #(.DEPTH(QDEPTH), .W(EW)) u_q (
    .clk(clk), .rst(rst),
    .in_valid(ev_valid), .in_ready(ev_ready), .in_data(ev_id),
    .pop(pop), .head(ev_cur), .empty(q_empty), .full(q_full)
  );

  hsm_select #(
    .NS(NS), .NT(NT), .NE(NE), .SW(SW), .EW(EW),
    .T_SRC(T_SRC), .T_EV(T_EV), .T_CONF(T_CONF)
  ) u_sel (
    .active(active), .go(go), .spont(spont), .ev_cur(ev_cur),
    .sel(sel), .any_sel(any_sel)
  );

  hsm_config #(
    .NS(NS), .NT(NT), .SW(SW),
    .T_EXIT(T_EXIT), .T_TGT(T_TGT),
    .S_PARENT(S_PARENT), .S_KIND(S_KIND), .S_DEF(S_DEF)
  ) u_cfg (
    .active(active), .sel(sel), .boot(boot & go),
    .exit_set(exit_raw), .entry_set(entry_raw), .next_active(next_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= '0;
      spont  <= 1'b1;
      boot   <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      err_q <= err_q | q_full;
      if (go) begin
        active <= next_active;
        boot   <= 1'b0;
        spont  <= spont ? (any_sel | boot) : 1'b1;
      end
    end
  end

  assign active_o = active;
  assign exit_o   = go ? exit_raw  : '0;
  assign entry_o  = go ? entry_raw : '0;
  assign sel_o    = sel;
  assign error    = err_q;
endmodule

// File: rtl/hsm_step_engine_chk.sv
module hsm_step_engine_chk #(
  parameter int NS = 8,
  parameter int NT = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [NS-1:0] active_o,
  input logic [NS-1:0] exit_o,
  input logic [NS-1:0] entry_o,
  input logic [NT-1:0] sel_o,
  input logic          completed,
  input logic          error
);
  a_r6_exit_within_active: assert property (@(posedge clk) disable iff (rst)
    (exit_o & ~active_o) == '0);

  a_r7_entry_not_staying: assert property (@(posedge clk) disable iff (rst)
    (entry_o & active_o & ~exit_o) == '0);

  a_r10_hold_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(active_o));

  a_r11_completed_idle: assert property (@(posedge clk) disable iff (rst)
    completed |-> (sel_o == '0 && entry_o == '0 && exit_o == '0));

  a_r13_error_sticky: assert property (@(posedge clk) disable iff (rst)
    error |=> error);
endmodule

bind hsm_step_engine hsm_step_engine_chk #(.NS(NS), .NT(NT)) u_chk (
  .clk(clk), .rst(rst), .en(en), .active_o(active_o), .exit_o(exit_o),
  .entry_o(entry_o), .sel_o(sel_o), .completed(completed), .error(error)
);

// File: tb/hsm_step_engine_bench.sv
module hsm_step_engine_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic       ev_valid = 1'b0;
  logic       ev_ready;
  logic [1:0] ev_id = '0;
  logic [7:0] active_o, exit_o, entry_o;
  logic [4:0] sel_o;
  logic       completed, error;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_q[$];
  logic [7:0] prev_act = '0;
  logic [4:0] last_sel = '0;
  logic [7:0] last_exit = '0, last_entry = '0, first_entry = '0;
  logic       seen_entry = 1'b0;

  always #5 clk = ~clk;

  hsm_step_engine u_hsm_step_engine (
    .clk(clk), .rst(rst), .en(en), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_id(ev_id), .active_o(active_o), .exit_o(exit_o), .entry_o(entry_o),
    .sel_o(sel_o), .completed(completed), .error(error)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: scoreboard of active-vector changes (R9), captures step vectors
  always @(negedge clk) begin
    if (rst) begin
      prev_act   = '0;
      seen_entry = 1'b0;
    end else begin
      if (sel_o != '0) begin
        last_sel   = sel_o;
        last_exit  = exit_o;
        last_entry = entry_o;
      end
      if (!seen_entry && entry_o != '0) begin
        first_entry = entry_o;
        seen_entry  = 1'b1;
      end
      if (active_o != prev_act) begin
        if (exp_q.size() == 0) chk(1'b0, "R9 unexpected step", 32'(active_o), 32'(prev_act));
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(active_o == e, "R9 active sequence", 32'(active_o), 32'(e));
        end
        prev_act = active_o;
      end
    end
  end

  task automatic send(input logic [1:0] id);
    @(negedge clk);
    ev_valid = 1'b1;
    ev_id    = id;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    en  = 1'b0;
    idle(3);
    chk(active_o == 8'h00, "R1 reset active", 32'(active_o), 32'h0);
    chk(error == 1'b0, "R1 reset error", 32'(error), 32'h0);
    chk(ev_ready == 1'b1, "R1 reset ready", 32'(ev_ready), 32'h1);
    rst = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // run 1: boot, eventless step, parallel entry, ignored event, priority
    do_reset();
    exp_q.push_back(8'h07);  // R1 boot with default chain (R8)
    exp_q.push_back(8'h0B);  // R2 eventless T0 while spontaneous
    en = 1'b1;
    idle(8);
    chk(first_entry == 8'h07, "R8 default chain on boot", 32'(first_entry), 32'h07);
    chk(last_sel == 5'b00001, "R4 eventless T0 selected", 32'(last_sel), 32'h01);
    chk(active_o == 8'h0B, "R2 idle after empty spontaneous step", 32'(active_o), 32'h0B);
    chk(exp_q.size() == 0, "R9 boot sequence consumed", 32'(exp_q.size()), 32'h0);

    exp_q.push_back(8'h71);
    send(2'd0);
    idle(6);
    chk(last_sel == 5'b00010, "R4 event T1 selected", 32'(last_sel), 32'h02);
    chk(last_exit == 8'h0A, "R6 exit only active states", 32'(last_exit), 32'h0A);
    chk(last_entry == 8'h70, "R7 parallel children entered", 32'(last_entry), 32'h70);
    chk(active_o == 8'h71, "R9 in parallel region", 32'(active_o), 32'h71);

    send(2'd2);
    idle(6);
    chk(active_o == 8'h71, "R4 unmatched event ignored", 32'(active_o), 32'h71);
    chk(last_sel == 5'b00010, "R4 unmatched event selects none", 32'(last_sel), 32'h02);

    exp_q.push_back(8'h81);
    send(2'd1);
    idle(6);
    chk(last_sel == 5'b00100, "R5 lower index wins conflict", 32'(last_sel), 32'h04);
    chk(active_o == 8'h81, "R5 single winner result", 32'(active_o), 32'h81);
    chk(completed == 1'b1, "R11 top final active", 32'(completed), 32'h1);

    send(2'd0);
    idle(6);
    chk(active_o == 8'h81, "R10 completed stalls", 32'(active_o), 32'h81);
    chk(ev_ready == 1'b1, "R12 queue has room", 32'(ev_ready), 32'h1);

    // run 2: fill the queue while held, then drain
    do_reset();
    chk(completed == 1'b0, "R11 completed clear after reset", 32'(completed), 32'h0);
    for (int k = 0; k < 4; k++) send(2'd2);
    chk(ev_ready == 1'b0, "R12 ready low when full", 32'(ev_ready), 32'h0);
    idle(1);
    chk(error == 1'b1, "R13 error after full", 32'(error), 32'h1);
    send(2'd0);  // offered while full: not stored
    idle(4);
    chk(active_o == 8'h00, "R10 enable low holds", 32'(active_o), 32'h0);
    exp_q.push_back(8'h07);
    exp_q.push_back(8'h0B);
    for (int k = 0; k < 4; k++) begin
      exp_q.push_back(8'h07);  // R3 event T4 back to A1
      exp_q.push_back(8'h0B);  // R3 eventless T0 on the next step
    end
    en = 1'b1;
    idle(40);
    chk(exp_q.size() == 0, "R3 event then spontaneous steps", 32'(exp_q.size()), 32'h0);
    chk(active_o == 8'h0B, "R12 dropped beat not consumed", 32'(active_o), 32'h0B);
    chk(last_entry == 8'h08, "R7 target entry for T0", 32'(last_entry), 32'h08);
    chk(error == 1'b1, "R13 error sticky", 32'(error), 32'h1);

    // run 3: reset clears error
    do_reset();
    idle(2);
    chk(error == 1'b0, "R13 error cleared by reset", 32'(error), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule